// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block is the user-level status and control register of a floating-point unit. It tracks the five IEEE 754 exceptions: invalid operation, division by zero, overflow, underflow and inexact. Each exception has a trap enable. When an exception arrives and its trap is disabled, the block sets a sticky cumulative flag and execution continues with the default result. When the trap is enabled, the block raises a trap request and leaves the sticky flag alone.

The register also holds a four-bit comparison result written by compare operations, a rounding-mode field, a flush-to-zero bit, and the short-vector length and stride fields. The rounding field, the flush-to-zero bit and the decoded vector shape are brought out to the datapath. The host processor decides conditional execution only from its own condition flags. The comparison result therefore reaches the host only when a transfer strobe copies it into a dedicated output register.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `rd_data` is zero, `host_flags` is zero, `trap_req` and `trap_cause` are zero, `round_mode` is 0, `flush_zero` is 0, `vec_elems` is 1 and `vec_step` is 1.
- R2: A write (`wr_en`) loads these fields from `wr_data`: sticky flags [4:0], trap enables [12:8], rounding mode [17:16], flush-to-zero [18], vector length minus one [22:20], stride select [24] and comparison flags [31:28]. All other bits read as zero. `rd_data` shows the register in the cycle after the write.
- R3: The exception bit order is 0 invalid, 1 divide by zero, 2 overflow, 3 underflow, 4 inexact. An exception pulse (`exc_valid` with `exc_bits`) on a bit whose trap enable is 0 sets that sticky flag in the next cycle. The flag stays set until a write of 0 clears it, and no trap is raised for that bit.
- R4: An exception on a bit whose trap enable is 1 drives `trap_req` high for exactly one cycle, in the next cycle, with that bit set in `trap_cause`. It leaves the sticky flag unchanged. The trap enables used are those held before the cycle of the event.
- R5: When a write and an untrapped exception occur in the same cycle, the sticky flag of the excepting bit ends up set, whatever the write data holds.
- R6: A compare update (`cmp_valid`) loads `cmp_flags` into bits [31:28]. A same-cycle write to that field loses to the compare update.
- R7: `host_flags` changes only in the cycle after `xfer_strobe`. It then takes the comparison field as it was held before that cycle, so a same-cycle compare update is not seen until the next transfer.
- R8: `round_mode` shows bits [17:16] with the encoding 00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. `flush_zero` shows bit [18].
- R9: `vec_elems` is the length field plus one (1 to 8) when `dbl_prec` is 0. When `dbl_prec` is 1 it is capped at 4. `vec_step` is 2 when bit [24] is 1 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| exc_valid | input | 1 | Exception event strobe from the datapath |
| exc_bits | input | 5 | Exceptions raised by the event |
| cmp_valid | input | 1 | Compare result update strobe |
| cmp_flags | input | 4 | Compare result (N, Z, C, V from bit 3 down) |
| xfer_strobe | input | 1 | Copy comparison field to host flags |
| dbl_prec | input | 1 | Current operation is double precision |
| host_flags | output | 4 | Condition flags delivered to the host |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 5 | Exceptions that caused the trap |
| round_mode | output | 2 | Rounding mode field |
| flush_zero | output | 1 | Flush-to-zero control |
| vec_elems | output | 4 | Elements in a short-vector operation |
| vec_step | output | 2 | Register stride between vector elements |

## Verification
The assertions assume that the inputs are defined at every clock edge after reset. They also assume that `exc_bits` and `cmp_flags` are only acted on when their strobes are high. The bench drives every input on the falling edge and holds the strobes for one cycle at a time, so each event is seen at exactly one rising edge. It returns the strobes to zero between stimuli. This lets the stability properties on the sticky flags and the host flags see quiet cycles.

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl #(
  parameter int MAX_SP_ELEMS = 8,
  parameter int MAX_DP_ELEMS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        exc_valid,
  input  logic [4:0]  exc_bits,
  input  logic        cmp_valid,
  input  logic [3:0]  cmp_flags,
  input  logic        xfer_strobe,
  input  logic        dbl_prec,
  output logic [3:0]  host_flags,
  output logic        trap_req,
  output logic [4:0]  trap_cause,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic [3:0]  vec_elems,
  output logic [1:0]  vec_step
);
  localparam int LW = $clog2(MAX_SP_ELEMS);

  logic [4:0]    sticky, trap_en;
  logic [1:0]    rnd_q;
  logic          fz_q, stride_q;
  logic [LW-1:0] len_q;
  logic [3:0]    cmp_q;

  logic [4:0] ev_trap, ev_flag;
  assign ev_trap = exc_valid ? (exc_bits & trap_en)  : 5'd0;
  assign ev_flag = exc_valid ? (exc_bits & ~trap_en) : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky   <= '0;
      trap_en  <= '0;
      rnd_q    <= '0;
      fz_q     <= 1'b0;
      len_q    <= '0;
      stride_q <= 1'b0;
      cmp_q    <= '0;
    end else begin
      sticky <= (wr_en ? wr_data[4:0] : sticky) | ev_flag;
      if (wr_en) begin
        trap_en  <= wr_data[12:8];
        rnd_q    <= wr_data[17:16];
        fz_q     <= wr_data[18];
        len_q    <= wr_data[20 +: LW];
        stride_q <= wr_data[24];
      end
      if (cmp_valid)  cmp_q <= cmp_flags;
      else if (wr_en) cmp_q <= wr_data[31:28];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_flags <= '0;
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      if (xfer_strobe) host_flags <= cmp_q;
      trap_req   <= |ev_trap;
      trap_cause <= ev_trap;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[4:0]       = sticky;
    rd_data[12:8]      = trap_en;
    rd_data[17:16]     = rnd_q;
    rd_data[18]        = fz_q;
    rd_data[20 +: LW]  = len_q;
    rd_data[24]        = stride_q;
    rd_data[31:28]     = cmp_q;
  end

  logic [3:0] sp_elems;
  assign sp_elems   = 4'({1'b0, len_q}) + 4'd1;
  assign vec_elems  = (dbl_prec && sp_elems > 4'(MAX_DP_ELEMS)) ? 4'(MAX_DP_ELEMS) : sp_elems;
  assign vec_step   = stride_q ? 2'd2 : 2'd1;
  assign round_mode = rnd_q;
  assign flush_zero = fz_q;

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !exc_valid) |=> $stable(sticky));

  p_trap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != 5'd0));

  p_trap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !trap_req);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && ((exc_bits & ~trap_en) != 5'd0))
      |=> ((sticky & $past(exc_bits & ~trap_en)) == $past(exc_bits & ~trap_en)));

  p_host_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_strobe |=> $stable(host_flags));

  p_elems_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_elems >= 4'd1) && (!dbl_prec || vec_elems <= 4'(MAX_DP_ELEMS)));
endmodule

// File: tb/test_fp_status_ctrl.sv
module test_fp_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, exc_valid = 0, cmp_valid = 0, xfer_strobe = 0, dbl_prec = 0;
  logic [31:0] wr_data = '0;
  logic [4:0] exc_bits = '0;
  logic [3:0] cmp_flags = '0;
  logic [31:0] rd_data;
  logic [3:0] host_flags, vec_elems;
  logic trap_req, flush_zero;
  logic [4:0] trap_cause;
  logic [1:0] round_mode, vec_step;
  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] MASK = 32'hF177_1F1F;

  always #4 clk = ~clk;

  fp_status_ctrl i_fp_status_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; exc_valid = 0; cmp_valid = 0; xfer_strobe = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wreg(logic [31:0] d);
    wr_en = 1; wr_data = d; cyc(); idle();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 rd_data", rd_data, 0);
    chk("R1 host", 32'(host_flags), 0);
    chk("R1 trap", {26'd0, trap_req, trap_cause}, 0);
    chk("R1 round/fz", {29'd0, round_mode, flush_zero}, 0);
    chk("R1 elems", 32'(vec_elems), 1);
    chk("R1 step", 32'(vec_step), 1);

    // R2 field layout and unused bits
    foreach (MASK[i]) begin
      wreg(32'h1 << i);
      chk("R2 bit", rd_data, (32'h1 << i) & MASK);
    end
    wreg(32'hFFFF_FFFF);
    chk("R2 all", rd_data, MASK);

    // R3/R4 sweep over enable masks and event patterns
    for (int m = 0; m < 4; m++) begin
      logic [4:0] en;
      en = (m == 0) ? 5'h00 : (m == 1) ? 5'h1F : (m == 2) ? 5'h0A : 5'h15;
      for (int b = 0; b < 32; b++) begin
        wreg({19'd0, en, 8'd0});
        exc_valid = 1; exc_bits = 5'(b); cyc(); idle(); exc_bits = 0;
        chk("R3 sticky", 32'(rd_data[4:0]), 32'(5'(b) & ~en));
        chk("R4 cause", 32'(trap_cause), 32'(5'(b) & en));
        chk("R4 req", 32'(trap_req), 32'(|(5'(b) & en)));
        cyc();
        chk("R4 one cycle", 32'(trap_req), 0);
        chk("R3 held", 32'(rd_data[4:0]), 32'(5'(b) & ~en));
      end
    end
    wreg(32'h0000_001F); cyc();
    chk("R3 held without write", 32'(rd_data[4:0]), 32'h1F);
    wreg(32'h0);
    chk("R3 cleared by write", 32'(rd_data[4:0]), 0);

    // R4 enable used is the one held before the event cycle
    wr_en = 1; wr_data = 32'h0000_1F00; exc_valid = 1; exc_bits = 5'h04; cyc(); idle();
    chk("R4 old enable", 32'(trap_req), 0);
    chk("R4 old enable sticky", 32'(rd_data[4:0]), 32'h04);

    // R5 event wins over same-cycle write
    wreg(32'h1F);
    wr_en = 1; wr_data = 32'h0; exc_valid = 1; exc_bits = 5'h09; cyc(); idle();
    chk("R5 event wins", 32'(rd_data[4:0]), 32'h09);

    // R6/R7 compare and transfer
    for (int v = 0; v < 16; v++) begin
      logic [3:0] prev;
      prev = host_flags;
      cmp_valid = 1; cmp_flags = 4'(v); cyc(); idle();
      chk("R6 cmp field", 32'(rd_data[31:28]), 32'(v));
      chk("R7 no transfer", 32'(host_flags), 32'(prev));
      xfer_strobe = 1; cyc(); idle();
      chk("R7 transfer", 32'(host_flags), 32'(v));
    end
    wr_en = 1; wr_data = 32'h5000_0000; cmp_valid = 1; cmp_flags = 4'hA; cyc(); idle();
    chk("R6 compare beats write", 32'(rd_data[31:28]), 32'hA);
    xfer_strobe = 1; cmp_valid = 1; cmp_flags = 4'h3; cyc(); idle();
    chk("R7 old value copied", 32'(host_flags), 32'hA);
    xfer_strobe = 1; cyc(); idle();
    chk("R7 next transfer", 32'(host_flags), 32'h3);

    // R8 rounding and flush
    for (int r = 0; r < 8; r++) begin
      wreg(32'(r) << 16);
      chk("R8 round", 32'(round_mode), 32'(r & 3));
      chk("R8 fz", 32'(flush_zero), 32'(r >> 2));
    end

    // R9 vector shape
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 8; l++) begin
        wreg((32'(s) << 24) | (32'(l) << 20));
        dbl_prec = 0; #1;
        chk("R9 sp elems", 32'(vec_elems), 32'(l + 1));
        dbl_prec = 1; #1;
        chk("R9 dp elems", 32'(vec_elems), (l + 1 > 4) ? 32'd4 : 32'(l + 1));
        chk("R9 step", 32'(vec_step), 32'(s + 1));
        dbl_prec = 0;
      end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule